// File: doc/BRIEF.md
# Host Bus Decoder with Vector Substitution

This block sits on the 24-bit bus that a cartridge coprocessor shares with the host processor. It decodes each read or write strobe into exactly one target select: the coprocessor register file, a 2 KB internal RAM, a banked 8 KB window into battery-backed work RAM (BWRAM), a linear BWRAM region, or ROM. For each selected target it also produces that target's index. The memory arrays, register file and interrupt logic live outside the block. They return their read bytes on dedicated inputs, and the block muxes the right byte onto its read data output.

The block keeps a small set of shadow registers that are cleared at reset. They hold a control byte, two 16-bit host vectors, three 16-bit coprocessor vectors and one BWRAM bank number for each bus master. They are loaded by snooping writes into the register window. A single `req_cop` input tells the block whether the coprocessor or the host issued the current access. That input picks which bank register drives the BWRAM window and which vector substitution rules apply. For host reads of the NMI and IRQ vector bytes in bank 0x00, the programmed vector replaces the ROM byte when its enable bit is set. Coprocessor reads of its reset, NMI and IRQ vector bytes always come from the shadow registers.

Top module: `dbus_vecdec`

## Requirements
- R1: An access in banks 0x00–0x3F with offset 0x2200–0x23FF asserts `sel_reg`, with `reg_idx` equal to address bits 8:0. Banks 0x80 and above never select registers.
- R2: An access in banks 0x00–0x3F with offset 0x3000–0x37FF asserts `sel_iram`, with `iram_idx` equal to address bits 10:0.
- R3: Offsets 0x6000–0x7FFF in any bank with address bit 22 clear select BWRAM at index bank×0x2000 + address bits 12:0. The bank is the host bank register (shadow offset 0x0B) for host accesses and the coprocessor bank register (offset 0x0C) for coprocessor accesses.
- R4: Banks 0x40–0x4F select BWRAM linearly, with the index equal to address bits 19:0.
- R5: ROM is selected only on reads, for offsets 0x8000–0xFFFF in banks with bit 22 clear and for every offset in banks 0xC0–0xFF. `rom_idx` is address bits 22:0. A write to a ROM-decoded address asserts no select.
- R6: At most one select is active. No select is active without a strobe. A read that decodes to no target returns 0x00.
- R7: When control bit 4 (shadow offset 0x00) is set, host reads of 0x00FFEA and 0x00FFEB return the host NMI vector low byte (offset 0x01) and high byte (offset 0x02) instead of ROM.
- R8: When control bit 6 is set, host reads of 0x00FFEE and 0x00FFEF return the host IRQ vector low byte (offset 0x03) and high byte (offset 0x04) instead of ROM.
- R9: Substitution applies only to those exact bank 0x00 addresses. The same offsets in other banks, and neighbouring offsets, read ROM data.
- R10: Coprocessor reads of 0x00FFFC/0x00FFFD, 0x00FFEA/0x00FFEB and 0x00FFEE/0x00FFEF always return the coprocessor reset vector (offsets 0x05/0x06), NMI vector (0x07/0x08) and IRQ vector (0x09/0x0A), low byte first.
- R11: Reset clears every shadow register. A write into the register window at one of the shadow offsets takes effect from the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 24 | Bus address (bank in bits 23:16) |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| req_cop | input | 1 | 1 = access issued by the coprocessor, 0 = by the host |
| wdata | input | 8 | Write data |
| reg_rdata | input | 8 | Read byte from the register file |
| iram_rdata | input | 8 | Read byte from internal RAM |
| bwram_rdata | input | 8 | Read byte from BWRAM |
| rom_rdata | input | 8 | Read byte from ROM |
| rdata | output | 8 | Read data returned to the bus |
| sel_reg | output | 1 | Register file select |
| sel_iram | output | 1 | Internal RAM select |
| sel_bwram | output | 1 | BWRAM select |
| sel_rom | output | 1 | ROM select |
| reg_idx | output | 9 | Register index |
| iram_idx | output | 11 | Internal RAM index |
| bwram_idx | output | BW_AW | BWRAM index |
| rom_idx | output | 23 | ROM index |

## Verification
On every cycle the assertions check the following: the selects are exclusive and never active without a strobe, ROM is selected only on reads, each register or RAM select falls inside its window, and unmapped reads return zero. Two cycle-to-cycle properties check that a cleared NMI enable lets ROM through and that a written coprocessor reset vector byte is returned on the next cycle. Only the bench scenarios can show which addresses fall into each window and how the per-master bank registers shape the BWRAM index. They also show that substitution is confined to exact bank 0x00 bytes.

// File: rtl/dbv_pkg.sv
package dbv_pkg;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_REG,
      TGT_IRAM,
      TGT_BWWIN,
      TGT_BWLIN,
      TGT_ROM
   } tgt_e;

   localparam int NSHADOW = 13;

   localparam int OFS_CTRL     = 0;
   localparam int OFS_HNMI_LO  = 1;
   localparam int OFS_HNMI_HI  = 2;
   localparam int OFS_HIRQ_LO  = 3;
   localparam int OFS_HIRQ_HI  = 4;
   localparam int OFS_CRST_LO  = 5;
   localparam int OFS_CRST_HI  = 6;
   localparam int OFS_CNMI_LO  = 7;
   localparam int OFS_CNMI_HI  = 8;
   localparam int OFS_CIRQ_LO  = 9;
   localparam int OFS_CIRQ_HI  = 10;
   localparam int OFS_HBANK    = 11;
   localparam int OFS_CBANK    = 12;

   localparam int CTRL_NMI_EN  = 4;
   localparam int CTRL_IRQ_EN  = 6;

endpackage

// File: rtl/dbv_region.sv
module dbv_region
   import dbv_pkg::*;
(
   input  logic [23:0] addr,
   output tgt_e        tgt
);
   logic [7:0]  bank;
   logic [15:0] ofs;

   assign bank = addr[23:16];
   assign ofs  = addr[15:0];

   always_comb begin
      tgt = TGT_NONE;
      if (bank[7:6] == 2'b11) begin
         tgt = TGT_ROM;
      end else if (bank[7:4] == 4'h4) begin
         tgt = TGT_BWLIN;
      end else if (!bank[6]) begin
         if (ofs[15])
            tgt = TGT_ROM;
         else if (ofs[15:13] == 3'b011)
            tgt = TGT_BWWIN;
         else if (!bank[7] && ofs[15:9] == 7'h11)
            tgt = TGT_REG;
         else if (!bank[7] && ofs[15:11] == 5'h06)
            tgt = TGT_IRAM;
      end
   end
endmodule

// File: rtl/dbv_shadow.sv
module dbv_shadow #(
   parameter int NREG  = 13,
   parameter int IDX_W = 9
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [IDX_W-1:0]           widx,
   input  logic [7:0]                 wdata,
   output logic [NREG-1:0][7:0]       q
);
   if (NREG > (1 << IDX_W)) begin : g_bad_nreg
      $error("dbv_shadow: NREG does not fit in the index");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= 8'h00;
         else if (we && widx == IDX_W'(i))
            q[i] <= wdata;
      end
   end
endmodule

// File: rtl/dbv_vecsel.sv
module dbv_vecsel
   import dbv_pkg::*;
#(
   parameter bit COP_VEC = 1'b1
) (
   input  logic [23:0]             addr,
   input  logic                    req_cop,
   input  logic [NSHADOW-1:0][7:0] q,
   output logic                    hit,
   output logic [7:0]              vdata
);
   logic       in_vpage;
   logic       host_hit, cop_hit;
   logic [7:0] host_data, cop_data;

   assign in_vpage = (addr[23:8] == 16'h00FF);

   always_comb begin
      host_hit  = 1'b0;
      host_data = 8'h00;
      case (addr[7:0])
         8'hEA: begin host_hit = q[OFS_CTRL][CTRL_NMI_EN]; host_data = q[OFS_HNMI_LO]; end
         8'hEB: begin host_hit = q[OFS_CTRL][CTRL_NMI_EN]; host_data = q[OFS_HNMI_HI]; end
         8'hEE: begin host_hit = q[OFS_CTRL][CTRL_IRQ_EN]; host_data = q[OFS_HIRQ_LO]; end
         8'hEF: begin host_hit = q[OFS_CTRL][CTRL_IRQ_EN]; host_data = q[OFS_HIRQ_HI]; end
         default: ;
      endcase
   end

   if (COP_VEC) begin : g_cop_vec
      always_comb begin
         cop_hit  = 1'b1;
         cop_data = 8'h00;
         case (addr[7:0])
            8'hFC:   cop_data = q[OFS_CRST_LO];
            8'hFD:   cop_data = q[OFS_CRST_HI];
            8'hEA:   cop_data = q[OFS_CNMI_LO];
            8'hEB:   cop_data = q[OFS_CNMI_HI];
            8'hEE:   cop_data = q[OFS_CIRQ_LO];
            8'hEF:   cop_data = q[OFS_CIRQ_HI];
            default: cop_hit  = 1'b0;
         endcase
      end
   end else begin : g_no_cop_vec
      assign cop_hit  = 1'b0;
      assign cop_data = 8'h00;
   end

   assign hit   = in_vpage && (req_cop ? cop_hit : host_hit);
   assign vdata = req_cop ? cop_data : host_data;
endmodule

// File: rtl/dbus_vecdec.sv
module dbus_vecdec
   import dbv_pkg::*;
#(
   parameter int BW_AW   = 20,
   parameter bit COP_VEC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [23:0]      addr,
   input  logic             rd,
   input  logic             wr,
   input  logic             req_cop,
   input  logic [7:0]       wdata,
   input  logic [7:0]       reg_rdata,
   input  logic [7:0]       iram_rdata,
   input  logic [7:0]       bwram_rdata,
   input  logic [7:0]       rom_rdata,
   output logic [7:0]       rdata,
   output logic             sel_reg,
   output logic             sel_iram,
   output logic             sel_bwram,
   output logic             sel_rom,
   output logic [8:0]       reg_idx,
   output logic [10:0]      iram_idx,
   output logic [BW_AW-1:0] bwram_idx,
   output logic [22:0]      rom_idx
);
   localparam int WIN_W  = 13;
   localparam int BANK_W = BW_AW - WIN_W;

   if (BW_AW < 14 || BW_AW > 20) begin : g_bad_bw
      $error("dbus_vecdec: BW_AW must lie in 14..20");
   end

   tgt_e                    tgt;
   logic                    access;
   logic                    vhit;
   logic [7:0]              vdata;
   logic [NSHADOW-1:0][7:0] shq;
   logic [7:0]              bank_sel;

   dbv_region i_region (
      .addr (addr),
      .tgt  (tgt)
   );

   dbv_shadow #(.NREG(NSHADOW), .IDX_W(9)) i_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr && tgt == TGT_REG),
      .widx  (addr[8:0]),
      .wdata (wdata),
      .q     (shq)
   );

   dbv_vecsel #(.COP_VEC(COP_VEC)) i_vecsel (
      .addr    (addr),
      .req_cop (req_cop),
      .q       (shq),
      .hit     (vhit),
      .vdata   (vdata)
   );

   assign access    = rd || wr;
   assign sel_reg   = access && tgt == TGT_REG;
   assign sel_iram  = access && tgt == TGT_IRAM;
   assign sel_bwram = access && (tgt == TGT_BWWIN || tgt == TGT_BWLIN);
   assign sel_rom   = rd && tgt == TGT_ROM;

   assign reg_idx   = addr[8:0];
   assign iram_idx  = addr[10:0];
   assign rom_idx   = addr[22:0];
   assign bank_sel  = req_cop ? shq[OFS_CBANK] : shq[OFS_HBANK];
   assign bwram_idx = (tgt == TGT_BWLIN) ? addr[BW_AW-1:0]
                                         : {bank_sel[BANK_W-1:0], addr[WIN_W-1:0]};

   always_comb begin
      rdata = 8'h00;
      if (rd) begin
         case (tgt)
            TGT_REG:   rdata = reg_rdata;
            TGT_IRAM:  rdata = iram_rdata;
            TGT_BWWIN,
            TGT_BWLIN: rdata = bwram_rdata;
            TGT_ROM:   rdata = vhit ? vdata : rom_rdata;
            default:   rdata = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/dbv_chk.sv
module dbv_chk #(
   parameter int BW_AW = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic [23:0]      addr,
   input logic             rd,
   input logic             wr,
   input logic             req_cop,
   input logic [7:0]       wdata,
   input logic [7:0]       rom_rdata,
   input logic [7:0]       rdata,
   input logic             sel_reg,
   input logic             sel_iram,
   input logic             sel_bwram,
   input logic             sel_rom
);
   logic any_sel;
   assign any_sel = sel_reg || sel_iram || sel_bwram || sel_rom;

   a_r6_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_reg, sel_iram, sel_bwram, sel_rom}));

   a_r6_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd || wr) |-> !any_sel);

   a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !any_sel) |-> rdata == 8'h00);

   a_r5_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      sel_rom |-> rd);

   a_r1_reg_window: assert property (@(posedge clk) disable iff (!rst_n)
      sel_reg |-> (addr[23:22] == 2'b00 && addr[15:9] == 7'h11));

   a_r2_iram_window: assert property (@(posedge clk) disable iff (!rst_n)
      sel_iram |-> (addr[23:22] == 2'b00 && addr[15:11] == 5'h06));

   a_r7_nmi_disabled_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel_reg && addr[8:0] == 9'h000 && !wdata[4])
      |=> ((rd && !wr && !req_cop && addr == 24'h00FFEA) -> rdata == rom_rdata));

   a_r10_cop_reset_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel_reg && addr[8:0] == 9'h005)
      |=> ((rd && !wr && req_cop && addr == 24'h00FFFC) -> rdata == $past(wdata)));
endmodule

bind dbus_vecdec dbv_chk #(.BW_AW(BW_AW)) i_chk (.*);

// File: tb/test_dbus_vecdec.sv
module test_dbus_vecdec;
   localparam int CLK_PERIOD = 10;
   localparam int BW_AW      = 20;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [23:0]      addr;
   logic             rd, wr, req_cop;
   logic [7:0]       wdata;
   logic [7:0]       reg_rdata, iram_rdata, bwram_rdata, rom_rdata;
   logic [7:0]       rdata;
   logic             sel_reg, sel_iram, sel_bwram, sel_rom;
   logic [8:0]       reg_idx;
   logic [10:0]      iram_idx;
   logic [BW_AW-1:0] bwram_idx;
   logic [22:0]      rom_idx;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   dbus_vecdec #(.BW_AW(BW_AW)) i_dbus_vecdec (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
      .req_cop(req_cop), .wdata(wdata),
      .reg_rdata(reg_rdata), .iram_rdata(iram_rdata),
      .bwram_rdata(bwram_rdata), .rom_rdata(rom_rdata),
      .rdata(rdata), .sel_reg(sel_reg), .sel_iram(sel_iram),
      .sel_bwram(sel_bwram), .sel_rom(sel_rom), .reg_idx(reg_idx),
      .iram_idx(iram_idx), .bwram_idx(bwram_idx), .rom_idx(rom_idx)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic put_reg(input logic [8:0] idx, input logic [7:0] d);
      addr  = 24'h002200 | {15'h0, idx};
      wdata = d;
      wr    = 1'b1;
      rd    = 1'b0;
      @(posedge clk);
      #1;
      wr    = 1'b0;
   endtask

   task automatic rd_at(input logic cop, input logic [23:0] a);
      req_cop = cop;
      addr    = a;
      rd      = 1'b1;
      wr      = 1'b0;
      #1;
   endtask

   task automatic idle();
      rd = 1'b0;
      wr = 1'b0;
      #1;
   endtask

   function automatic logic [3:0] sels();
      return {sel_reg, sel_iram, sel_bwram, sel_rom};
   endfunction

   task automatic t_reset();
      rd_at(1'b0, 24'h00FFEA);
      chk("R11 reset: host NMI byte reads ROM", rdata, 8'h44);
      rd_at(1'b1, 24'h00FFFC);
      chk("R11 reset: cop reset vector cleared", rdata, 8'h00);
      rd_at(1'b0, 24'h006010);
      chk("R11 reset: host bank zero", bwram_idx, 20'h00010);
      idle();
      chk("R6 no strobe no select", sels(), 4'b0000);
   endtask

   task automatic t_regs_iram();
      rd_at(1'b0, 24'h002200);
      chk("R1 reg sel", sels(), 4'b1000);
      chk("R1 reg idx low", reg_idx, 9'h000);
      chk("R1 reg data", rdata, 8'h11);
      rd_at(1'b0, 24'h3F23FF);
      chk("R1 reg idx high", reg_idx, 9'h1FF);
      rd_at(1'b0, 24'h802200);
      chk("R1 bank 80 no reg", sels(), 4'b0000);
      chk("R6 bank 80 reg offset zero", rdata, 8'h00);
      rd_at(1'b0, 24'h3F3000);
      chk("R2 iram sel", sels(), 4'b0100);
      chk("R2 iram data", rdata, 8'h22);
      rd_at(1'b0, 24'h0037FF);
      chk("R2 iram idx top", iram_idx, 11'h7FF);
      rd_at(1'b0, 24'h003800);
      chk("R6 past iram unmapped", sels(), 4'b0000);
      chk("R6 past iram zero", rdata, 8'h00);
      idle();
   endtask

   task automatic t_bwram();
      put_reg(9'h00B, 8'h05);
      put_reg(9'h00C, 8'h09);
      rd_at(1'b0, 24'h006123);
      chk("R3 host window sel", sels(), 4'b0010);
      chk("R3 host bank idx", bwram_idx, 20'h0A123);
      chk("R3 bwram data", rdata, 8'h33);
      rd_at(1'b1, 24'h806123);
      chk("R3 cop bank idx", bwram_idx, 20'h12123);
      rd_at(1'b0, 24'h4ABCDE);
      chk("R4 linear sel", sels(), 4'b0010);
      chk("R4 linear idx", bwram_idx, 20'hABCDE);
      rd_at(1'b0, 24'h402200);
      chk("R4 bank 40 reg offset is bwram", bwram_idx, 20'h02200);
      rd_at(1'b0, 24'h501234);
      chk("R6 bank 50 unmapped", rdata, 8'h00);
      idle();
   endtask

   task automatic t_rom();
      rd_at(1'b0, 24'h018000);
      chk("R5 rom sel", sels(), 4'b0001);
      chk("R5 rom idx", rom_idx, 23'h018000);
      chk("R5 rom data", rdata, 8'h44);
      rd_at(1'b0, 24'hC01234);
      chk("R5 high bank rom idx", rom_idx, 23'h401234);
      addr = 24'h008000; wr = 1'b1; rd = 1'b0; #1;
      chk("R5 rom write ignored", sels(), 4'b0000);
      idle();
      rd_at(1'b0, 24'h000000);
      chk("R6 low page unmapped", rdata, 8'h00);
      idle();
   endtask

   task automatic t_nmi();
      put_reg(9'h001, 8'hAB);
      put_reg(9'h002, 8'hCD);
      put_reg(9'h000, 8'h10);
      rd_at(1'b0, 24'h00FFEA);
      chk("R7 nmi lo", rdata, 8'hAB);
      rd_at(1'b0, 24'h00FFEB);
      chk("R7 nmi hi", rdata, 8'hCD);
      rd_at(1'b0, 24'h00FFEE);
      chk("R8 irq disabled reads rom", rdata, 8'h44);
      rd_at(1'b0, 24'h01FFEA);
      chk("R9 other bank reads rom", rdata, 8'h44);
      rd_at(1'b0, 24'h80FFEA);
      chk("R9 mirror bank reads rom", rdata, 8'h44);
      idle();
   endtask

   task automatic t_irq();
      put_reg(9'h003, 8'h5A);
      put_reg(9'h004, 8'hA5);
      put_reg(9'h000, 8'h40);
      rd_at(1'b0, 24'h00FFEE);
      chk("R8 irq lo", rdata, 8'h5A);
      rd_at(1'b0, 24'h00FFEF);
      chk("R8 irq hi", rdata, 8'hA5);
      rd_at(1'b0, 24'h00FFEA);
      chk("R7 nmi disabled again", rdata, 8'h44);
      rd_at(1'b0, 24'h00FFEC);
      chk("R9 neighbour offset rom", rdata, 8'h44);
      idle();
   endtask

   task automatic t_cop();
      put_reg(9'h005, 8'h34);
      rd_at(1'b1, 24'h00FFFC);
      chk("R11 next cycle write visible", rdata, 8'h34);
      put_reg(9'h006, 8'h12);
      put_reg(9'h007, 8'h78);
      put_reg(9'h008, 8'h56);
      put_reg(9'h009, 8'hBC);
      put_reg(9'h00A, 8'h9A);
      rd_at(1'b1, 24'h00FFFD);
      chk("R10 cop reset hi", rdata, 8'h12);
      rd_at(1'b1, 24'h00FFEA);
      chk("R10 cop nmi lo", rdata, 8'h78);
      rd_at(1'b1, 24'h00FFEB);
      chk("R10 cop nmi hi", rdata, 8'h56);
      rd_at(1'b1, 24'h00FFEE);
      chk("R10 cop irq lo", rdata, 8'hBC);
      rd_at(1'b1, 24'h00FFEF);
      chk("R10 cop irq hi", rdata, 8'h9A);
      rd_at(1'b1, 24'h00FFF0);
      chk("R10 cop other offset rom", rdata, 8'h44);
      rd_at(1'b0, 24'h00FFFC);
      chk("R10 host reset byte rom", rdata, 8'h44);
      idle();
   endtask

   initial begin
      rst_n = 1'b0; rd = 1'b0; wr = 1'b0; req_cop = 1'b0;
      addr = 24'h0; wdata = 8'h0;
      reg_rdata = 8'h11; iram_rdata = 8'h22; bwram_rdata = 8'h33; rom_rdata = 8'h44;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_regs_iram();
      t_bwram();
      t_rom();
      t_nmi();
      t_irq();
      t_cop();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule